// File: doc/BRIEF.md
# Segment Selector Load Checker

This block loads one segment register of a CPU that runs with protected segmentation. When `start_i` is pulsed it takes a 16-bit selector and the current privilege level. It checks the selector against the global descriptor table, which is given by a base address and a byte limit. If the selector passes, the block reads the 8-byte descriptor as two 32-bit words over a valid/ready memory port. It then checks that the descriptor is present and that the caller's privilege is sufficient. A descriptor that passes every check is kept whole in a shadow register, and the selector is kept with it. The block then pulses `done_o`. Any failed check pulses `fault_o` and gives a fault code.

Later accesses through the segment are checked against the cached copy only, so the table is not read again. The address check is combinational. It forms the effective limit from the 20-bit limit field and the granularity bit, and it forms the linear address from the cached base. When `long_mode_i` is high, the base and limit checks are bypassed and only the privilege check made at load time applies. A flag also reports whether the cached descriptor is a 64-bit code segment.

Top module: `seg_load_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fault_o`, `mem_req_o` and `chk_ok_o` are all 0, and the shadow cache is marked empty.
- R2: A selector with bit 2 (table indicator) set faults with code 1 in the cycle after `start_i`, and no memory read is issued.
- R3: The table byte offset is the selector with its low 3 bits cleared. If offset+7 is greater than `gdt_limit_i`, the load faults with code 1 in the cycle after `start_i`, and no memory read is issued. If offset+7 equals the limit, the load proceeds.
- R4: An accepted load issues exactly two reads. The first is at base+offset and returns the low word; the second is at base+offset+4 and returns the high word. Each read holds `mem_req_o` and its address stable until `mem_ready_i`.
- R5: A descriptor with bit 47 (present) clear faults with code 3. This takes priority over a privilege failure.
- R6: A present descriptor whose DPL (bits 46:45) is lower than the captured CPL faults with code 2. When CPL is less than or equal to DPL, the load completes with `done_o`.
- R7: On success, `shadow_o` takes the 64-bit descriptor {high word, low word} and `sel_o` takes the selector, in the cycle `done_o` is high. A fault leaves both unchanged.
- R8: `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` or `fault_o` pulses for one cycle; in that cycle it is low. A `start_i` that arrives while busy is ignored.
- R9: Outside long mode, the effective limit is the 20-bit value {bits 51:48, bits 15:0}. When bit 55 is 1 this value is shifted left by 12 with 0xFFF filled in below. `chk_ok_o` is 1 when the cache is loaded and `chk_off_i` is at most the effective limit. `chk_lin_o` is base {bits 63:56, bits 39:16} plus `chk_off_i`.
- R10: In long mode, `chk_ok_o` is 1 whenever the cache is loaded, and `chk_lin_o` equals `chk_off_i`.
- R11: `code64_o` is 1 when the cache is loaded and the cached descriptor has bits 44 and 43 set (code), bit 53 (L) set, and bit 54 (D/B) clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a selector load |
| sel_i | input | 16 | Selector to load |
| cpl_i | input | 2 | Current privilege level |
| long_mode_i | input | 1 | Privilege-only checking for addresses |
| gdt_base_i | input | ADDR_W | Descriptor table base address |
| gdt_limit_i | input | 16 | Descriptor table byte limit |
| mem_req_o | output | 1 | Read request valid |
| mem_addr_o | output | ADDR_W | Read address |
| mem_ready_i | input | 1 | Read data returned |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load succeeded (pulse) |
| fault_o | output | 1 | Load refused (pulse) |
| fault_code_o | output | 2 | 1 table bounds, 2 privilege, 3 not present |
| shadow_o | output | 64 | Cached descriptor |
| sel_o | output | 16 | Selector of cached descriptor |
| code64_o | output | 1 | Cached descriptor is a 64-bit code segment |
| chk_off_i | input | 32 | Offset to check against the cache |
| chk_ok_o | output | 1 | Offset permitted |
| chk_lin_o | output | 32 | Linear address of the offset |

## Verification
A load can commit a new descriptor in the same cycle that the address check is being used. Because the check is combinational on the cache, `chk_ok_o` and `chk_lin_o` switch to the new descriptor in exactly the cycle `done_o` is high. The bench holds a random offset and a random mode for the whole of each load. It compares the check outputs against the old cached descriptor in every busy cycle, and against the newly fetched one in the done cycle. A second overlap, a restart while busy, is provoked by pulsing `start_i` with a bad selector in the middle of a fetch. The bench then judges that only the first load completes, with exactly two reads.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int DESC_W = 64;
  localparam int WORD_W = 32;
  localparam int LIN_W  = 32;
  localparam int LIM20_W = 20;

  localparam int B_PRESENT = 47;
  localparam int B_DPL_LO  = 45;
  localparam int B_GRAN    = 55;
  localparam int B_DB      = 54;
  localparam int B_LONG    = 53;
  localparam int B_SYS_N   = 44;
  localparam int B_EXEC    = 43;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BOUNDS = 2'd1,
    FLT_PRIV   = 2'd2,
    FLT_ABSENT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_EVAL
  } ld_state_e;
endpackage

// File: rtl/seg_table_bound.sv
module seg_table_bound #(
  parameter int SEL_W = 16,
  parameter int LIM_W = 16
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic [SEL_W-1:0] off_o,
  output logic             ok_o
);
  localparam int CMP_W = (SEL_W > LIM_W ? SEL_W : LIM_W) + 1;

  logic [CMP_W-1:0] last_byte;

  assign off_o     = {sel_i[SEL_W-1:3], 3'b000};
  assign last_byte = CMP_W'(off_o) + CMP_W'(7);
  // bit 2 selects the local table, which is not supported
  assign ok_o      = !sel_i[2] && (last_byte <= CMP_W'(limit_i));
endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
  import seg_pkg::*;
(
  input  logic       present_i,
  input  logic [1:0] dpl_i,
  input  logic [1:0] cpl_i,
  output fault_e     code_o
);
  always_comb begin
    if (!present_i)          code_o = FLT_ABSENT;
    else if (cpl_i > dpl_i)  code_o = FLT_PRIV;
    else                     code_o = FLT_NONE;
  end
endmodule

// File: rtl/seg_fetch_ctl.sv
module seg_fetch_ctl
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [1:0]        cpl_i,
  input  logic              bound_ok_i,
  input  logic [ADDR_W-1:0] tab_addr_i,
  input  fault_e            eval_code_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output fault_e            code_o,
  output logic              commit_o,
  output logic [DESC_W-1:0] desc_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [1:0]        cpl_o
);
  ld_state_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] lo_q, hi_q;
  logic [SEL_W-1:0]  sel_q;
  logic [1:0]        cpl_q;
  logic              done_q, fault_q;
  fault_e            code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      sel_q   <= '0;
      cpl_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      code_q  <= FLT_NONE;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          sel_q <= sel_i;
          cpl_q <= cpl_i;
          if (!bound_ok_i) begin
            fault_q <= 1'b1;
            code_q  <= FLT_BOUNDS;
          end else begin
            addr_q <= tab_addr_i;
            st_q   <= ST_LO;
          end
        end
        ST_LO: if (mem_ready_i) begin
          lo_q   <= mem_rdata_i;
          addr_q <= addr_q + ADDR_W'(4);
          st_q   <= ST_HI;
        end
        ST_HI: if (mem_ready_i) begin
          hi_q <= mem_rdata_i;
          st_q <= ST_EVAL;
        end
        ST_EVAL: begin
          st_q   <= ST_IDLE;
          code_q <= eval_code_i;
          if (eval_code_i == FLT_NONE) done_q  <= 1'b1;
          else                         fault_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == ST_LO) || (st_q == ST_HI);
  assign mem_addr_o = addr_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign code_o     = code_q;
  assign commit_o   = (st_q == ST_EVAL) && (eval_code_i == FLT_NONE);
  assign desc_o     = {hi_q, lo_q};
  assign sel_o      = sel_q;
  assign cpl_o      = cpl_q;
endmodule

// File: rtl/seg_shadow.sv
module seg_shadow
  import seg_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              long_mode_i,
  input  logic [LIN_W-1:0]  chk_off_i,
  output logic [DESC_W-1:0] shadow_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              valid_o,
  output logic              code64_o,
  output logic              chk_ok_o,
  output logic [LIN_W-1:0]  chk_lin_o
);
  logic [DESC_W-1:0]  desc_q;
  logic [SEL_W-1:0]   sel_q;
  logic               valid_q;
  logic [LIM20_W-1:0] lim20;
  logic [LIN_W-1:0]   eff_lim, base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_q  <= '0;
      sel_q   <= '0;
      valid_q <= 1'b0;
    end else if (commit_i) begin
      desc_q  <= desc_i;
      sel_q   <= sel_i;
      valid_q <= 1'b1;
    end
  end

  assign lim20   = {desc_q[51:48], desc_q[15:0]};
  assign eff_lim = desc_q[B_GRAN] ? {lim20, 12'hFFF} : LIN_W'(lim20);
  assign base    = {desc_q[63:56], desc_q[39:16]};

  assign chk_ok_o  = valid_q && (long_mode_i || (chk_off_i <= eff_lim));
  assign chk_lin_o = long_mode_i ? chk_off_i : base + chk_off_i;
  assign code64_o  = valid_q && desc_q[B_SYS_N] && desc_q[B_EXEC]
                     && desc_q[B_LONG] && !desc_q[B_DB];
  assign shadow_o  = desc_q;
  assign sel_o     = sel_q;
  assign valid_o   = valid_q;
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int LIM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [1:0]        cpl_i,
  input  logic              long_mode_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [LIM_W-1:0]  gdt_limit_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_code_o,
  output logic [63:0]       shadow_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              code64_o,
  input  logic [31:0]       chk_off_i,
  output logic              chk_ok_o,
  output logic [31:0]       chk_lin_o
);
  logic [SEL_W-1:0]  tab_off;
  logic              bound_ok;
  fault_e            eval_code, code;
  logic              commit;
  logic [DESC_W-1:0] fetched;
  logic [SEL_W-1:0]  sel_cap;
  logic [1:0]        cpl_cap;
  logic              shd_valid;

  seg_table_bound #(.SEL_W(SEL_W), .LIM_W(LIM_W)) u_bound (
    .sel_i   (sel_i),
    .limit_i (gdt_limit_i),
    .off_o   (tab_off),
    .ok_o    (bound_ok)
  );

  seg_desc_check u_dchk (
    .present_i (fetched[B_PRESENT]),
    .dpl_i     (fetched[B_DPL_LO+1:B_DPL_LO]),
    .cpl_i     (cpl_cap),
    .code_o    (eval_code)
  );

  seg_fetch_ctl #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .sel_i       (sel_i),
    .cpl_i       (cpl_i),
    .bound_ok_i  (bound_ok),
    .tab_addr_i  (gdt_base_i + ADDR_W'(tab_off)),
    .eval_code_i (eval_code),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .code_o      (code),
    .commit_o    (commit),
    .desc_o      (fetched),
    .sel_o       (sel_cap),
    .cpl_o       (cpl_cap)
  );

  seg_shadow #(.SEL_W(SEL_W)) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_i    (commit),
    .desc_i      (fetched),
    .sel_i       (sel_cap),
    .long_mode_i (long_mode_i),
    .chk_off_i   (chk_off_i),
    .shadow_o    (shadow_o),
    .sel_o       (sel_o),
    .valid_o     (shd_valid),
    .code64_o    (code64_o),
    .chk_ok_o    (chk_ok_o),
    .chk_lin_o   (chk_lin_o)
  );

  assign fault_code_o = code;
endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              fault_o,
  input logic [1:0]        fault_code_o,
  input logic              mem_req_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [63:0]       shadow_o,
  input logic              valid_i,
  input logic              long_mode_i,
  input logic              chk_ok_o,
  input logic [31:0]       chk_lin_o,
  input logic [31:0]       chk_off_i
);
  a_r1_req_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  a_r4_second_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mem_req_o) && $past(mem_ready_i) && mem_req_o
      |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(4));

  a_r8_single_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  a_r8_idle_on_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> !busy_o);

  a_r3_bounds_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && fault_code_o == 2'd1 |-> !$past(busy_o));

  a_r7_cache_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shadow_o) |-> done_o);

  a_r10_long_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_mode_i && valid_i |-> chk_ok_o && chk_lin_o == chk_off_i);
endmodule

bind seg_load_unit seg_load_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .fault_code_o (fault_code_o),
  .mem_req_o    (mem_req_o),
  .mem_ready_i  (mem_ready_i),
  .mem_addr_o   (mem_addr_o),
  .shadow_o     (shadow_o),
  .valid_i      (shd_valid),
  .long_mode_i  (long_mode_i),
  .chk_ok_o     (chk_ok_o),
  .chk_lin_o    (chk_lin_o),
  .chk_off_i    (chk_off_i)
);

// File: tb/seg_load_unit_tb_top.sv
module seg_load_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] sel = '0;
  logic [1:0]  cpl = '0;
  logic        long_mode = 1'b0;
  logic [31:0] gdt_base = '0;
  logic [15:0] gdt_limit = '0;
  logic        mem_req, mem_ready;
  logic [31:0] mem_addr, mem_rdata;
  logic        busy, done, fault;
  logic [1:0]  fcode;
  logic [63:0] shadow;
  logic [15:0] sel_out;
  logic        code64;
  logic [31:0] chk_off = '0;
  logic        chk_ok;
  logic [31:0] chk_lin;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_load_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sel_i(sel), .cpl_i(cpl),
    .long_mode_i(long_mode), .gdt_base_i(gdt_base), .gdt_limit_i(gdt_limit),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .fault_o(fault),
    .fault_code_o(fcode), .shadow_o(shadow), .sel_o(sel_out), .code64_o(code64),
    .chk_off_i(chk_off), .chk_ok_o(chk_ok), .chk_lin_o(chk_lin)
  );

  logic [63:0] tbl [16];
  int          n_chk = 0, n_bad = 0;
  int          rd_cnt = 0, lat = 0;
  logic [31:0] rd_addr [4];
  logic [63:0] m_shd = '0;
  logic [15:0] m_sel = '0;
  logic        m_valid = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input logic [31:0] a);
    logic [31:0] off = a - gdt_base;
    return off[2] ? tbl[off[6:3]][63:32] : tbl[off[6:3]][31:0];
  endfunction

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
      input logic g, p, input logic [1:0] dpl, input logic s, x, lb, db);
    logic [63:0] d = '0;
    d[15:0] = l[15:0]; d[51:48] = l[19:16];
    d[39:16] = b[23:0]; d[63:56] = b[31:24];
    d[55] = g; d[47] = p; d[46:45] = dpl; d[44] = s; d[43] = x; d[53] = lb; d[54] = db;
    return d;
  endfunction

  function automatic logic [1:0] exp_code(input logic [15:0] s, input logic [1:0] c,
      input logic [15:0] lim);
    logic [16:0] last = {1'b0, s[15:3], 3'b000} + 17'd7;
    logic [63:0] d;
    if (s[2] || last > {1'b0, lim}) return 2'd1;
    d = tbl[s[6:3]];
    if (!d[47]) return 2'd3;
    if (c > d[46:45]) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [32:0] exp_chk(input logic [63:0] d, input logic v,
      input logic lm, input logic [31:0] off);
    logic [19:0] l20 = {d[51:48], d[15:0]};
    logic [31:0] eff = d[55] ? {l20, 12'hFFF} : {12'h0, l20};
    logic [31:0] base = {d[63:56], d[39:16]};
    return {v && (lm || off <= eff), lm ? off : base + off};
  endfunction

  task automatic check_addr(input string tag);
    logic [32:0] e = exp_chk(m_shd, m_valid, long_mode, chk_off);
    check({tag, " ok"}, {63'd0, chk_ok}, {63'd0, e[32]});
    if (m_valid) check({tag, " lin"}, {32'd0, chk_lin}, {32'd0, e[31:0]});
  endtask

  // memory responder: drives at the falling edge
  initial begin
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ready = 1'b0;
      if (mem_req) begin
        if (lat == 0) begin
          mem_ready = 1'b1;
          mem_rdata = word_at(mem_addr);
          if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr;
          rd_cnt++;
          lat = $urandom % 3;
        end else lat--;
      end
    end
  end

  // one selector load; chk outputs compared against old cache while busy, new at done (R9/R10)
  task automatic do_load(input logic [15:0] s, input logic [1:0] c, input bit restart);
    logic [1:0] ec = exp_code(s, c, gdt_limit);
    logic [31:0] off = {16'd0, s[15:3], 3'b000};
    bit seen = 0;
    @(negedge clk);
    sel = s; cpl = c; start = 1'b1; rd_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 60 && !seen; i++) begin
      if (done || fault) seen = 1;
      else begin
        check("R8 busy while loading", {63'd0, busy}, 64'd1);
        check_addr("R9 old cache during load");
        if (restart && i == 1) begin
          sel = 16'h0004; start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end else @(negedge clk);
      end
    end
    check("R8 outcome seen", {63'd0, seen}, 64'd1);
    check("R8 busy low at outcome", {63'd0, busy}, 64'd0);
    if (ec == 2'd0) begin
      check("R6 done", {62'd0, done, fault}, 64'd2);
      m_shd = tbl[s[6:3]]; m_sel = s; m_valid = 1'b1;
    end else begin
      check("R5 R6 fault", {62'd0, done, fault}, 64'd1);
      check(ec == 2'd3 ? "R5 code" : ec == 2'd2 ? "R6 code" : "R2 R3 code",
            {62'd0, fcode}, {62'd0, ec});
    end
    check("R7 shadow", shadow, m_shd);
    check("R7 sel", {48'd0, sel_out}, {48'd0, m_sel});
    check_addr("R9 new cache at done");
    check("R11 code64", {63'd0, code64},
          {63'd0, m_valid && m_shd[44] && m_shd[43] && m_shd[53] && !m_shd[54]});
    check("R4 read count", rd_cnt, ec == 2'd1 ? 0 : 2);
    if (ec != 2'd1) begin
      check("R4 low word addr", {32'd0, rd_addr[0]}, {32'd0, gdt_base + off});
      check("R4 high word addr", {32'd0, rd_addr[1]}, {32'd0, gdt_base + off + 32'd4});
    end
    @(negedge clk);
    check("R8 pulse one cycle", {62'd0, done, fault}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2468));
    for (int i = 0; i < 16; i++) tbl[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    check("R1 busy", {63'd0, busy}, 64'd0);
    check("R1 done fault", {62'd0, done, fault}, 64'd0);
    check("R1 mem_req", {63'd0, mem_req}, 64'd0);
    check("R1 chk_ok", {63'd0, chk_ok}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    gdt_base  = 32'h0004_0000;
    gdt_limit = 16'd127;
    tbl[1] = mk(32'h0, 20'hFFFFF, 1, 1, 2'd3, 1, 0, 0, 0);
    tbl[2] = mk(32'h0000_1000, 20'h00010, 0, 1, 2'd3, 1, 0, 0, 0);
    tbl[3] = mk(32'h0, 20'h0, 0, 1, 2'd0, 1, 1, 1, 0);
    tbl[4] = mk(32'h0, 20'h0, 0, 0, 2'd0, 1, 0, 0, 0);
    tbl[5] = mk(32'h0, 20'h0, 0, 1, 2'd2, 1, 0, 0, 0);
    do_load(16'h000C, 2'd0, 0);                 // R2 table indicator set
    do_load(16'h0008, 2'd3, 0);                 // R9 granular full limit
    chk_off = 32'hFFFF_FFFF; #1 check_addr("R9 granular max");
    do_load(16'h0010, 2'd1, 0);                 // R9 byte limit
    chk_off = 32'h10; #1 check_addr("R9 at limit");
    chk_off = 32'h11; #1 check_addr("R9 past limit");
    long_mode = 1'b1; #1 check_addr("R10 long bypass");
    long_mode = 1'b0;
    do_load(16'h0018, 2'd0, 0);                 // R11 64-bit code
    do_load(16'h0020, 2'd3, 0);                 // R5 absent beats privilege
    do_load(16'h002B, 2'd2, 0);                 // R6 cpl equal dpl
    do_load(16'h0028, 2'd3, 0);                 // R6 cpl above dpl
    gdt_limit = 16'd47; do_load(16'h0028, 2'd0, 0);  // R3 last byte at limit
    gdt_limit = 16'd46; do_load(16'h0028, 2'd0, 0);  // R3 one short
    gdt_limit = 16'd127;
    do_load(16'h0029, 2'd1, 1);                 // R8 restart ignored

    for (int i = 0; i < 16; i++) begin
      tbl[i] = {$urandom, $urandom};
      tbl[i][47] = ($urandom % 4) != 0;
    end
    for (int n = 0; n < 400; n++) begin
      gdt_base  = $urandom & 32'hFFFF_FFF8;
      gdt_limit = 16'($urandom % 128);
      long_mode = $urandom % 2;
      chk_off   = ($urandom % 2) ? $urandom : ($urandom % 32'h2_0000);
      do_load(16'($urandom % 18) << 3 | 16'($urandom % 8), 2'($urandom), 0);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule